// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of six bus masters owns a shared bus. Five of the masters are external requester/grant pairs. The sixth, at the highest index, is the chip's own internal master. A configuration vector places each master in either the high-priority pool or the low-priority pool.

High-pool masters share the bus in a round-robin rotation. Low-pool masters never compete directly. Instead, one of them at a time holds a promoted slot inside the high rotation, and it gives up that slot the moment it is granted. The slot then passes on round-robin through the low pool. In this way the whole low pool shares a single turn in the high rotation.

New grant decisions are taken only on cycles where the bus-idle input is high. With nothing requested, the grant parks on the internal master. Clearing the enable input withdraws every grant, so that an external arbiter can take over.

Top module: `two_level_rr_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant vector is all zeros.
- R2: No more than one bit of the grant vector is ever high.
- R3: While enable stays high, a clock edge seen with bus-idle low leaves the grant vector unchanged.
- R4: A clock edge seen with enable low drives the grant vector to all zeros, including the internal master's bit.
- R5: An edge seen with enable and bus-idle high and no request pending parks the grant on bit 5, the internal master. Parking leaves the rotation state untouched.
- R6: Pool selection is one bit per master: 1 places it in the high pool, 0 in the low pool. Among high-pool requesters, grants rotate in ascending index order. The search starts just above the last master granted from the rotation and wraps from 5 to 0.
- R7: Exactly one low-pool requester is promoted at a time. It is the first requesting low-pool master at or above the low pointer, searching with wrap. It competes in the high rotation at its own index position. No other low-pool master is granted.
- R8: When the promoted master is granted, the low pointer moves to the index just above it, so promotion passes to the next low-pool requester.
- R9: A master that drops its request before being served is skipped. The rotation positions are not reset by this.
- R10: Whenever requests are pending on an enabled, idle edge, the new grant goes to a master that was requesting on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 6 | Request vector; bit 5 is the internal master |
| hi_sel | input | 6 | Pool select per master: 1 high pool, 0 low pool |
| arb_en | input | 1 | 1 enables the arbiter; 0 releases all grants |
| bus_idle | input | 1 | 1 when the bus is free and a new grant may be issued |
| gnt | output | 6 | Registered one-hot-or-zero grant vector |

## Verification
The bench builds the block with its default parameters: six masters, parking enabled, and the park index on the internal master. This puts a high-pool internal master between the top low-pool member and the wrap. The low pointer therefore has to skip a high member while it wraps.

The vector table covers several pool configurations: mixed pools, all-low and all-high. Under the all-low setting the only path to the bus is through promotion. The table also includes cases where promoted members drop their requests, and cases where the low pointer lands on a non-low index.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
   // index one above i, wrapping inside 0..n-1
   function automatic int wrap_next(input int i, input int n);
      return (i + 1) % n;
   endfunction
endpackage

// File: rtl/arb2_rr_pick.sv
module arb2_rr_pick
   import arb2_pkg::*;
#(
   parameter int N  = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] base,
   output logic [N-1:0]  pick_oh,
   output logic [IW-1:0] pick_idx,
   output logic          pick_vld
);
   // first set request at or above base, wrapping
   always_comb begin
      pick_oh  = '0;
      pick_idx = '0;
      pick_vld = 1'b0;
      for (int off = 0; off < N; off++) begin
         automatic int idx = (int'(base) + off) % N;
         if (!pick_vld && req[idx]) begin
            pick_vld     = 1'b1;
            pick_idx     = IW'(idx);
            pick_oh[idx] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/two_level_rr_arb.sv
module two_level_rr_arb
   import arb2_pkg::*;
#(
   parameter int NUM_REQ  = 6,
   parameter bit PARK_EN  = 1'b1,
   parameter int PARK_IDX = NUM_REQ - 1,
   localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req,
   input  logic [NUM_REQ-1:0] hi_sel,
   input  logic               arb_en,
   input  logic               bus_idle,
   output logic [NUM_REQ-1:0] gnt
);
   if (NUM_REQ < 2) begin : g_chk_n
      $error("two_level_rr_arb: NUM_REQ must be at least 2");
   end
   if (PARK_IDX < 0 || PARK_IDX >= NUM_REQ) begin : g_chk_park
      $error("two_level_rr_arb: PARK_IDX out of range");
   end

   logic [NUM_REQ-1:0] gnt_q, park_vec;
   logic [IW-1:0]      last_hi, lo_ptr, hi_base;
   logic [NUM_REQ-1:0] low_req, hi_req, cand;
   logic [NUM_REQ-1:0] promo_oh, win_oh;
   logic [IW-1:0]      promo_idx, win_idx;
   logic               promo_vld, win_vld;

   if (PARK_EN) begin : g_park
      always_comb begin
         park_vec           = '0;
         park_vec[PARK_IDX] = 1'b1;
      end
   end else begin : g_nopark
      assign park_vec = '0;
   end

   assign low_req = req & ~hi_sel;
   assign hi_req  = req &  hi_sel;

   // level 2: choose which low-pool member holds the promoted slot
   arb2_rr_pick #(.N(NUM_REQ)) u_lo_pick (
      .req      (low_req),
      .base     (lo_ptr),
      .pick_oh  (promo_oh),
      .pick_idx (promo_idx),
      .pick_vld (promo_vld)
   );

   assign cand    = hi_req | (promo_vld ? promo_oh : '0);
   assign hi_base = IW'(wrap_next(int'(last_hi), NUM_REQ));

   // level 1: rotation over high members plus the promoted one
   arb2_rr_pick #(.N(NUM_REQ)) u_hi_pick (
      .req      (cand),
      .base     (hi_base),
      .pick_oh  (win_oh),
      .pick_idx (win_idx),
      .pick_vld (win_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q   <= '0;
         last_hi <= IW'(NUM_REQ - 1);
         lo_ptr  <= '0;
      end else if (!arb_en) begin
         gnt_q <= '0;
      end else if (bus_idle) begin
         if (win_vld) begin
            gnt_q   <= win_oh;
            last_hi <= win_idx;
            if (promo_vld && (win_idx == promo_idx))
               lo_ptr <= IW'(wrap_next(int'(promo_idx), NUM_REQ));
         end else begin
            gnt_q <= park_vec;
         end
      end
   end

   assign gnt = gnt_q;
endmodule

// File: rtl/two_level_rr_arb_chk.sv
module two_level_rr_arb_chk #(
   parameter int NUM_REQ  = 6,
   parameter bit PARK_EN  = 1'b1,
   parameter int PARK_IDX = NUM_REQ - 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] req,
   input logic               arb_en,
   input logic               bus_idle,
   input logic [NUM_REQ-1:0] gnt
);
   localparam logic [NUM_REQ-1:0] PARK_VEC =
      PARK_EN ? (NUM_REQ'(1) << PARK_IDX) : '0;

   always @(posedge clk)
      if (!rst_n) assert_reset_R1: assert (gnt == '0);

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && !bus_idle) |=> (!arb_en || $stable(gnt)));

   assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_en |=> (gnt == '0));

   assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && bus_idle && req == '0) |=> (gnt == PARK_VEC));

   assert_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && bus_idle && req != '0) |=> ((gnt & $past(req)) != '0));
endmodule

bind two_level_rr_arb two_level_rr_arb_chk #(
   .NUM_REQ(NUM_REQ), .PARK_EN(PARK_EN), .PARK_IDX(PARK_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .arb_en(arb_en),
   .bus_idle(bus_idle), .gnt(gnt)
);

// File: tb/two_level_rr_arb_tb.sv
module two_level_rr_arb_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] req = '0, hi_sel = '0, gnt;
   logic       arb_en = 1'b0, bus_idle = 1'b0;
   int         n_tests = 0, n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   two_level_rr_arb u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .hi_sel(hi_sel),
      .arb_en(arb_en), .bus_idle(bus_idle), .gnt(gnt)
   );

   // {hi_sel, req, arb_en, bus_idle, expected gnt, requirement}
   localparam int NV = 21;
   localparam logic [23:0] VEC [NV] = '{
      {6'b100011, 6'b000000, 1'b1, 1'b1, 6'b100000, 4'd5},  // R5 park
      {6'b100011, 6'b000011, 1'b1, 1'b1, 6'b000001, 4'd6},  // R6
      {6'b100011, 6'b000011, 1'b1, 1'b1, 6'b000010, 4'd6},  // R6
      {6'b100011, 6'b000011, 1'b1, 1'b1, 6'b000001, 4'd6},  // R6 wrap
      {6'b100011, 6'b011111, 1'b1, 1'b1, 6'b000010, 4'd7},  // R7 2 promoted
      {6'b100011, 6'b011111, 1'b1, 1'b1, 6'b000100, 4'd7},  // R7
      {6'b100011, 6'b011111, 1'b1, 1'b1, 6'b001000, 4'd8},  // R8 next low
      {6'b100011, 6'b011111, 1'b1, 1'b1, 6'b010000, 4'd8},  // R8
      {6'b100011, 6'b011111, 1'b1, 1'b1, 6'b000001, 4'd6},  // R6
      {6'b100011, 6'b011111, 1'b1, 1'b0, 6'b000001, 4'd3},  // R3 hold
      {6'b100011, 6'b011111, 1'b1, 1'b1, 6'b000010, 4'd3},  // R3 resumes
      {6'b100011, 6'b010011, 1'b1, 1'b1, 6'b010000, 4'd9},  // R9 skip 2,3
      {6'b100011, 6'b100000, 1'b1, 1'b1, 6'b100000, 4'd10}, // R10
      {6'b100011, 6'b100000, 1'b0, 1'b1, 6'b000000, 4'd4},  // R4 off
      {6'b100011, 6'b000000, 1'b1, 1'b1, 6'b100000, 4'd5},  // R5
      {6'b000000, 6'b000110, 1'b1, 1'b1, 6'b000010, 4'd7},  // R7 all low
      {6'b000000, 6'b000110, 1'b1, 1'b1, 6'b000100, 4'd8},  // R8
      {6'b000000, 6'b000110, 1'b1, 1'b1, 6'b000010, 4'd8},  // R8 wrap
      {6'b111111, 6'b101000, 1'b1, 1'b1, 6'b001000, 4'd6},  // R6 all high
      {6'b111111, 6'b101000, 1'b1, 1'b1, 6'b100000, 4'd6},  // R6
      {6'b111111, 6'b101000, 1'b1, 1'b1, 6'b001000, 4'd6}   // R6
   };

   task automatic check(input logic [5:0] exp, input int rq, input string what);
      n_tests++;
      if (gnt !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: gnt=%b expected=%b", rq, what, gnt, exp);
      end
      n_tests++;
      if ($countones(gnt) > 1) begin   // R2
         n_fail++;
         $display("FAIL R2 %s: gnt=%b expected at most one bit", what, gnt);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 check(6'b000000, 1, "during reset");           // R1
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #2 check(6'b000000, 1, "after reset"); // R1
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         hi_sel   = VEC[i][23:18];
         req      = VEC[i][17:12];
         arb_en   = VEC[i][11];
         bus_idle = VEC[i][10];
         @(posedge clk);
         #2 check(VEC[i][9:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
      end
      // directed: reset in the middle of a run clears the grant (R1)
      @(negedge clk) rst_n = 1'b0;
      #2 check(6'b000000, 1, "mid-run reset");
      @(negedge clk) rst_n = 1'b1;
      hi_sel = 6'b000011; req = 6'b000011; arb_en = 1'b1; bus_idle = 1'b1;
      // rotation restarts at index 0 after reset (R6)
      @(posedge clk); #2 check(6'b000001, 6, "restart after reset");
      // idle low with a new requester: grant is held (R3)
      @(negedge clk) bus_idle = 1'b0; req = 6'b000010;
      @(posedge clk); #2 check(6'b000001, 3, "held while busy");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule